// File: doc/BRIEF.md
# Virtual Function Capability Registers and Routing-ID Decoder

This block holds the configuration registers of a single-root I/O virtualization capability and performs the routing arithmetic that links virtual function (VF) numbers to 16-bit routing IDs. Software reaches the registers through a simple dword-addressed port with byte enables. Writes take effect at the clock edge. Read data is combinational from the address.

Two further ports serve the datapath. The forward port takes a VF index and returns the routing ID of that VF one cycle later. It also flags whether the VF is currently live. The lookup port takes the routing ID of an incoming request or completion. One cycle later it reports whether that ID belongs to a live VF, and if so which one. It also splits the ID into bus, device and function fields, following either the classic 5-bit device / 3-bit function layout or the alternative layout with an 8-bit function number.

The VF routing ID for index N is `PF_RID + FIRST_OFS + N*STRIDE`, taken modulo 2^16. PF_RID, FIRST_OFS and STRIDE are build parameters. The lookup inverts this mapping.

Top module: `vf_route_cap`

## Requirements
- R1: After reset: dword 0 reads 0x0001_0010 (capability ID 0x0010 in bits 15:0, version 1 in bits 19:16); control (dword 2) reads 0; the VF count in use (dword 4, bits 15:0) reads 0; the selected page size (dword 8) reads 1; `lk_done`, `lk_hit` and `fwd_ok` are 0.
- R2: These read-only dwords ignore writes:
  - dword 3 = {TOTAL_VFS in bits 31:16, INITIAL_VFS in bits 15:0}
  - dword 5 = {STRIDE in bits 31:16, FIRST_OFS in bits 15:0}
  - dword 6 = {VF_DEVID in bits 31:16, 0 in bits 15:0}
  - dword 7 = PAGE_SIZES
- R3: Control bits are written only through byte lane 0:
  - bit 0 is VF enable
  - bit 3 is VF memory enable
  - bit 4 selects the 8-bit-function ID layout
  - all other control bits read 0.
- R4: A write to the VF count in use is ignored while VF enable is set.
- R5: The VF count in use is written through byte lanes 1:0, merged with its old bytes. A merged value above TOTAL_VFS is stored as TOTAL_VFS.
- R6: The selected page size (dword 8) is written byte by byte; only lanes whose enable is set change.
- R7: Dwords 1 and 9 to 15, and the upper half of dword 4, read 0, and writes to them change nothing.
- R8: One cycle after `fwd_req` is raised:
  - `fwd_rid` = (PF_RID + FIRST_OFS + `fwd_idx`*STRIDE) mod 2^16
  - `fwd_ok` = VF enable and (`fwd_idx` < VF count in use)
- R9: One cycle after `lk_valid` is raised, `lk_done` is 1. `lk_hit` is 1 only when all of these hold:
  - VF enable is set
  - d = `lk_rid` − PF_RID − FIRST_OFS is non-negative
  - d is a multiple of STRIDE
  - d/STRIDE is below the VF count in use

  On a hit, `lk_idx` = d/STRIDE; otherwise `lk_idx` = 0.
- R10: The lookup always reports `lk_bus` = `lk_rid`[15:8]. In the classic layout (control bit 4 clear), `lk_dev` = `lk_rid`[7:3] and `lk_func` = `lk_rid`[2:0]. In the 8-bit-function layout, `lk_dev` = 0 and `lk_func` = `lk_rid`[7:0].
- R11: With STRIDE = 0, only d = 0 can hit, giving index 0, and only when the VF count in use is nonzero.
- R12: A lookup or forward request in the same cycle as a configuration write uses the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Dword index within the capability |
| cfg_be | input | 4 | Byte lane enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` |
| fwd_req | input | 1 | Forward request strobe |
| fwd_idx | input | IDX_W | VF index to map |
| fwd_ok | output | 1 | Mapped VF is live |
| fwd_rid | output | 16 | Routing ID of the VF |
| lk_valid | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Routing ID to decode |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | ID belongs to a live VF |
| lk_idx | output | IDX_W | VF index on a hit |
| lk_bus | output | 8 | Bus field of the ID |
| lk_dev | output | 5 | Device field (0 in 8-bit-function layout) |
| lk_func | output | 8 | Function field |

## Verification
A configuration write to the control register and a lookup can land in the same clock edge. For example, one write turns VF enable on while a lookup of the first VF's ID is in flight, and another turns it off. The bench drives both in one cycle and expects the result that the pre-write enable gives: a miss when enabling, a hit when disabling. The lookup that follows must then reflect the new enable. The random phase mixes control writes, count writes, lookups and forward requests, and compares every outcome against a bench model of the registers.

// File: rtl/vfr_pkg.sv
package vfr_pkg;
    localparam int RID_W  = 16;
    localparam int CFG_AW = 4;

    localparam logic [CFG_AW-1:0] DW_HDR   = 4'd0;
    localparam logic [CFG_AW-1:0] DW_CTRL  = 4'd2;
    localparam logic [CFG_AW-1:0] DW_VFCNT = 4'd3;
    localparam logic [CFG_AW-1:0] DW_NUM   = 4'd4;
    localparam logic [CFG_AW-1:0] DW_RIDMAP= 4'd5;
    localparam logic [CFG_AW-1:0] DW_DEVID = 4'd6;
    localparam logic [CFG_AW-1:0] DW_PGCAP = 4'd7;
    localparam logic [CFG_AW-1:0] DW_PGSEL = 4'd8;

    localparam logic [15:0] CAP_ID  = 16'h0010;
    localparam logic [3:0]  CAP_VER = 4'h1;

    localparam int CB_EN  = 0;
    localparam int CB_MSE = 3;
    localparam int CB_ARI = 4;
endpackage

// File: rtl/vfr_regs.sv
module vfr_regs
    import vfr_pkg::*;
#(
    parameter int          TOTAL_VFS   = 64,
    parameter int          INITIAL_VFS = 16,
    parameter logic [15:0] FIRST_OFS   = 16'h0100,
    parameter logic [15:0] STRIDE      = 16'h0001,
    parameter logic [15:0] VF_DEVID    = 16'h10CA,
    parameter logic [31:0] PAGE_SIZES  = 32'h0000_0553
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              vf_en,
    output logic              ari_mode,
    output logic [15:0]       num_vfs
);
    localparam logic [15:0] TOTAL_W = 16'(TOTAL_VFS);
    localparam logic [15:0] INIT_W  = 16'(INITIAL_VFS);

    logic        en_q, mse_q, ari_q;
    logic [15:0] num_q;
    logic [31:0] pgsel_q;
    logic [15:0] num_merge;

    always_comb begin
        num_merge[15:8] = cfg_be[1] ? cfg_wdata[15:8] : num_q[15:8];
        num_merge[7:0]  = cfg_be[0] ? cfg_wdata[7:0]  : num_q[7:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            mse_q   <= 1'b0;
            ari_q   <= 1'b0;
            num_q   <= '0;
            pgsel_q <= 32'h1;
        end else if (cfg_we) begin
            if (cfg_addr == DW_CTRL && cfg_be[0]) begin
                en_q  <= cfg_wdata[CB_EN];
                mse_q <= cfg_wdata[CB_MSE];
                ari_q <= cfg_wdata[CB_ARI];
            end
            if (cfg_addr == DW_NUM && (|cfg_be[1:0]) && !en_q)
                num_q <= (num_merge > TOTAL_W) ? TOTAL_W : num_merge;
            if (cfg_addr == DW_PGSEL) begin
                for (int b = 0; b < 4; b++)
                    if (cfg_be[b]) pgsel_q[8*b +: 8] <= cfg_wdata[8*b +: 8];
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            DW_HDR:    cfg_rdata = {12'h000, CAP_VER, CAP_ID};
            DW_CTRL: begin
                cfg_rdata[CB_EN]  = en_q;
                cfg_rdata[CB_MSE] = mse_q;
                cfg_rdata[CB_ARI] = ari_q;
            end
            DW_VFCNT:  cfg_rdata = {TOTAL_W, INIT_W};
            DW_NUM:    cfg_rdata = {16'h0000, num_q};
            DW_RIDMAP: cfg_rdata = {STRIDE, FIRST_OFS};
            DW_DEVID:  cfg_rdata = {VF_DEVID, 16'h0000};
            DW_PGCAP:  cfg_rdata = PAGE_SIZES;
            DW_PGSEL:  cfg_rdata = pgsel_q;
            default:   cfg_rdata = '0;
        endcase
    end

    assign vf_en    = en_q;
    assign ari_mode = ari_q;
    assign num_vfs  = num_q;

    // R4: count frozen while enabled
    p_num_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> $stable(num_q));
    // R5: count never exceeds the total
    p_num_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        num_q <= TOTAL_W);
endmodule

// File: rtl/vfr_fwd.sv
module vfr_fwd #(
    parameter logic [15:0] PF_RID    = 16'h0200,
    parameter logic [15:0] FIRST_OFS = 16'h0100,
    parameter logic [15:0] STRIDE    = 16'h0001,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwd_req,
    input  logic [IDX_W-1:0] fwd_idx,
    input  logic             vf_en,
    input  logic [15:0]      num_vfs,
    output logic             fwd_ok,
    output logic [15:0]      fwd_rid
);
    localparam logic [15:0] BASE = PF_RID + FIRST_OFS;

    logic [15:0] idx16;
    logic [15:0] rid_n;

    assign idx16 = 16'(fwd_idx);
    assign rid_n = BASE + idx16 * STRIDE;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fwd_ok  <= 1'b0;
            fwd_rid <= '0;
        end else begin
            fwd_ok <= fwd_req && vf_en && (idx16 < num_vfs);
            if (fwd_req) fwd_rid <= rid_n;
        end
    end

    // R8: no live answer while disabled
    p_fwd_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && !vf_en) |=> !fwd_ok);
    // R8: index at or past the count is never live
    p_fwd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_req && (idx16 >= num_vfs)) |=> !fwd_ok);
endmodule

// File: rtl/vfr_rev.sv
module vfr_rev #(
    parameter logic [15:0] PF_RID    = 16'h0200,
    parameter logic [15:0] FIRST_OFS = 16'h0100,
    parameter logic [15:0] STRIDE    = 16'h0001,
    parameter int          IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [15:0]      lk_rid,
    input  logic             vf_en,
    input  logic             ari_mode,
    input  logic [15:0]      num_vfs,
    output logic             lk_done,
    output logic             lk_hit,
    output logic [IDX_W-1:0] lk_idx,
    output logic [7:0]       lk_bus,
    output logic [4:0]       lk_dev,
    output logic [7:0]       lk_func
);
    localparam logic [17:0] BASE = 18'(PF_RID) + 18'(FIRST_OFS);

    logic        below;
    logic [15:0] d16;
    logic [15:0] quo;
    logic        aligned;
    logic        hit_n;

    assign below = {2'b00, lk_rid} < BASE;
    assign d16   = lk_rid - BASE[15:0];

    generate
        if (STRIDE == 16'd0) begin : g_zero
            assign quo     = '0;
            assign aligned = (d16 == 16'd0);
        end else begin : g_div
            assign quo     = d16 / STRIDE;
            assign aligned = ((d16 % STRIDE) == 16'd0);
        end
    endgenerate

    assign hit_n = vf_en && !below && aligned && (quo < num_vfs);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lk_done <= 1'b0;
            lk_hit  <= 1'b0;
            lk_idx  <= '0;
            lk_bus  <= '0;
            lk_dev  <= '0;
            lk_func <= '0;
        end else begin
            lk_done <= lk_valid;
            lk_hit  <= lk_valid && hit_n;
            if (lk_valid) begin
                lk_idx  <= hit_n ? quo[IDX_W-1:0] : '0;
                lk_bus  <= lk_rid[15:8];
                lk_dev  <= ari_mode ? 5'd0 : lk_rid[7:3];
                lk_func <= ari_mode ? lk_rid[7:0] : {5'd0, lk_rid[2:0]};
            end
        end
    end

    // R9: result follows request by one cycle
    p_done_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> lk_done);
    // R9: no hit while disabled
    p_hit_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !vf_en) |=> !lk_hit);
    // R9: hit index below the count sampled with the request
    p_hit_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!lk_hit || (16'(lk_idx) < $past(num_vfs))));
    // R10: device field cleared in the 8-bit-function layout
    p_ari_dev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && ari_mode) |=> (lk_dev == 5'd0));
    // R10: classic layout keeps function to three bits
    p_trad_func_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !ari_mode) |=> (lk_func[7:3] == 5'd0));
endmodule

// File: rtl/vf_route_cap.sv
module vf_route_cap
    import vfr_pkg::*;
#(
    parameter logic [15:0] PF_RID      = 16'h0200,
    parameter logic [15:0] FIRST_OFS   = 16'h0100,
    parameter logic [15:0] STRIDE      = 16'h0001,
    parameter int          TOTAL_VFS   = 64,
    parameter int          INITIAL_VFS = 16,
    parameter logic [15:0] VF_DEVID    = 16'h10CA,
    parameter logic [31:0] PAGE_SIZES  = 32'h0000_0553,
    localparam int         IDX_W       = $clog2(TOTAL_VFS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [3:0]        cfg_be,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              fwd_req,
    input  logic [IDX_W-1:0]  fwd_idx,
    output logic              fwd_ok,
    output logic [RID_W-1:0]  fwd_rid,
    input  logic              lk_valid,
    input  logic [RID_W-1:0]  lk_rid,
    output logic              lk_done,
    output logic              lk_hit,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [7:0]        lk_bus,
    output logic [4:0]        lk_dev,
    output logic [7:0]        lk_func
);
    logic        vf_en;
    logic        ari_mode;
    logic [15:0] num_vfs;

    vfr_regs #(
        .TOTAL_VFS(TOTAL_VFS), .INITIAL_VFS(INITIAL_VFS), .FIRST_OFS(FIRST_OFS),
        .STRIDE(STRIDE), .VF_DEVID(VF_DEVID), .PAGE_SIZES(PAGE_SIZES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .vf_en(vf_en), .ari_mode(ari_mode), .num_vfs(num_vfs)
    );

    vfr_fwd #(
        .PF_RID(PF_RID), .FIRST_OFS(FIRST_OFS), .STRIDE(STRIDE), .IDX_W(IDX_W)
    ) u_fwd (
        .clk(clk), .rst_n(rst_n), .fwd_req(fwd_req), .fwd_idx(fwd_idx),
        .vf_en(vf_en), .num_vfs(num_vfs), .fwd_ok(fwd_ok), .fwd_rid(fwd_rid)
    );

    vfr_rev #(
        .PF_RID(PF_RID), .FIRST_OFS(FIRST_OFS), .STRIDE(STRIDE), .IDX_W(IDX_W)
    ) u_rev (
        .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_rid(lk_rid),
        .vf_en(vf_en), .ari_mode(ari_mode), .num_vfs(num_vfs),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_idx(lk_idx),
        .lk_bus(lk_bus), .lk_dev(lk_dev), .lk_func(lk_func)
    );
endmodule

// File: tb/vf_route_cap_bench.sv
module vf_route_cap_bench;
    localparam logic [15:0] PF    = 16'h0200;
    localparam logic [15:0] OFS   = 16'h0100;
    localparam logic [15:0] STR   = 16'd3;
    localparam int          TOT   = 64;
    localparam int          INI   = 16;
    localparam logic [15:0] DEVID = 16'h1234;
    localparam logic [31:0] PGS   = 32'h0000_0553;
    localparam int          IW    = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [3:0] cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic fwd_req = 1'b0;
    logic [IW-1:0] fwd_idx = '0;
    logic lk_valid = 1'b0;
    logic [15:0] lk_rid = '0;

    logic [31:0] rdata_a, rdata_z;
    logic fok_a, fok_z, done_a, done_z, hit_a, hit_z;
    logic [15:0] frid_a, frid_z;
    logic [IW-1:0] idx_a, idx_z;
    logic [7:0] bus_a, bus_z, func_a, func_z;
    logic [4:0] dev_a, dev_z;

    int n_total = 0;
    int n_bad = 0;

    int m_en = 0, m_ari = 0, m_num = 0;
    logic [31:0] m_pg = 32'h1;

    always #10 clk = ~clk;

    vf_route_cap #(
        .PF_RID(PF), .FIRST_OFS(OFS), .STRIDE(STR), .TOTAL_VFS(TOT),
        .INITIAL_VFS(INI), .VF_DEVID(DEVID), .PAGE_SIZES(PGS)
    ) u_vf_route_cap (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_a),
        .fwd_req(fwd_req), .fwd_idx(fwd_idx), .fwd_ok(fok_a), .fwd_rid(frid_a),
        .lk_valid(lk_valid), .lk_rid(lk_rid), .lk_done(done_a), .lk_hit(hit_a),
        .lk_idx(idx_a), .lk_bus(bus_a), .lk_dev(dev_a), .lk_func(func_a)
    );

    vf_route_cap #(
        .PF_RID(PF), .FIRST_OFS(OFS), .STRIDE(16'd0), .TOTAL_VFS(TOT),
        .INITIAL_VFS(INI), .VF_DEVID(DEVID), .PAGE_SIZES(PGS)
    ) u_vf_route_cap_z (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rdata_z),
        .fwd_req(fwd_req), .fwd_idx(fwd_idx), .fwd_ok(fok_z), .fwd_rid(frid_z),
        .lk_valid(lk_valid), .lk_rid(lk_rid), .lk_done(done_z), .lk_hit(hit_z),
        .lk_idx(idx_z), .lk_bus(bus_z), .lk_dev(dev_z), .lk_func(func_z)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_total++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic int exp_rev(int rid, int strd);
        int d;
        d = rid - int'(PF) - int'(OFS);
        if (m_en == 0 || d < 0) return -1;
        if (strd == 0) return (d == 0 && m_num > 0) ? 0 : -1;
        if (d % strd != 0) return -1;
        if (d / strd >= m_num) return -1;
        return d / strd;
    endfunction

    task automatic model_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
        int merged;
        if (a == 4'd2 && be[0]) begin
            m_en = int'(d[0]);
            m_ari = int'(d[4]);
        end
        if (a == 4'd4 && (|be[1:0]) && m_en == 0) begin
            merged = m_num;
            if (be[0]) merged = (merged & 32'hFF00) | int'(d[7:0]);
            if (be[1]) merged = (merged & 32'h00FF) | (int'(d[15:8]) << 8);
            m_num = (merged > TOT) ? TOT : merged;
        end
        if (a == 4'd8)
            for (int b = 0; b < 4; b++)
                if (be[b]) m_pg[8*b +: 8] = d[8*b +: 8];
    endtask

    task automatic cfg_wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; cfg_be = be;
        @(negedge clk);
        cfg_we = 1'b0;
        model_wr(a, d, be);
    endtask

    task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, rdata_a, exp);
    endtask

    task automatic lk_check(int rid, int e_a, int e_z);
        chk("R9 done", 32'(done_a), 32'd1);
        chk("R9 hit", 32'(hit_a), 32'(e_a >= 0));
        chk("R9 idx", 32'(idx_a), 32'(e_a >= 0 ? e_a : 0));
        chk("R10 bus", 32'(bus_a), 32'((rid >> 8) & 255));
        chk("R10 dev", 32'(dev_a), 32'(m_ari != 0 ? 0 : (rid >> 3) & 31));
        chk("R10 func", 32'(func_a), 32'(m_ari != 0 ? rid & 255 : rid & 7));
        chk("R11 hit", 32'(hit_z), 32'(e_z >= 0));
        chk("R11 idx", 32'(idx_z), 32'(e_z >= 0 ? e_z : 0));
    endtask

    task automatic lookup(int rid);
        int e_a, e_z;
        @(negedge clk);
        lk_valid = 1'b1; lk_rid = 16'(rid);
        e_a = exp_rev(rid, int'(STR));
        e_z = exp_rev(rid, 0);
        @(negedge clk);
        lk_valid = 1'b0;
        lk_check(rid, e_a, e_z);
    endtask

    // R12: control write and lookup in the same cycle
    task automatic lookup_with_ctrl(int rid, logic [31:0] ctrl);
        int e_a, e_z;
        @(negedge clk);
        lk_valid = 1'b1; lk_rid = 16'(rid);
        cfg_we = 1'b1; cfg_addr = 4'd2; cfg_wdata = ctrl; cfg_be = 4'h1;
        e_a = exp_rev(rid, int'(STR));
        e_z = exp_rev(rid, 0);
        @(negedge clk);
        lk_valid = 1'b0; cfg_we = 1'b0;
        chk("R12 hit", 32'(hit_a), 32'(e_a >= 0));
        lk_check(rid, e_a, e_z);
        model_wr(4'd2, ctrl, 4'h1);
    endtask

    task automatic fwd(int idx);
        int live;
        @(negedge clk);
        fwd_req = 1'b1; fwd_idx = IW'(idx);
        live = (m_en != 0 && idx < m_num) ? 1 : 0;
        @(negedge clk);
        fwd_req = 1'b0;
        chk("R8 ok", 32'(fok_a), 32'(live));
        chk("R8 rid", 32'(frid_a), 32'((int'(PF) + int'(OFS) + idx * int'(STR)) & 16'hFFFF));
        chk("R11 fwd rid", 32'(frid_z), 32'(int'(PF) + int'(OFS)));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_total++; n_bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 hdr", 4'd0, 32'h0001_0010);
        rd_chk("R1 ctrl", 4'd2, 32'h0);
        rd_chk("R1 num", 4'd4, 32'h0);
        rd_chk("R1 pgsel", 4'd8, 32'h1);
        chk("R1 done", 32'(done_a), 32'd0);
        chk("R1 hit", 32'(hit_a), 32'd0);
        chk("R1 fok", 32'(fok_a), 32'd0);

        // R2 read-only fields
        cfg_wr(4'd3, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd5, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd6, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd7, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R2 counts", 4'd3, {16'(TOT), 16'(INI)});
        rd_chk("R2 ridmap", 4'd5, {STR, OFS});
        rd_chk("R2 devid", 4'd6, {DEVID, 16'h0});
        rd_chk("R2 pages", 4'd7, PGS);

        // R7 reserved space
        cfg_wr(4'd1, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd9, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd15, 32'hFFFF_FFFF, 4'hF);
        cfg_wr(4'd4, 32'hFFFF_FFFF, 4'hC);
        rd_chk("R7 dw1", 4'd1, 32'h0);
        rd_chk("R7 dw9", 4'd9, 32'h0);
        rd_chk("R7 dw15", 4'd15, 32'h0);
        rd_chk("R7 num hi", 4'd4, 32'h0);

        // R3 control bits
        cfg_wr(4'd2, 32'hFFFF_FFFF, 4'hE);
        rd_chk("R3 lane0 only", 4'd2, 32'h0);
        cfg_wr(4'd2, 32'hFFFF_FFFF, 4'hF);
        rd_chk("R3 ctrl set", 4'd2, 32'h19);
        cfg_wr(4'd2, 32'h0, 4'hF);
        rd_chk("R3 ctrl clr", 4'd2, 32'h0);

        // R5 clamp and merge
        cfg_wr(4'd4, 32'd100, 4'h3);
        rd_chk("R5 clamp", 4'd4, 32'(TOT));
        cfg_wr(4'd4, 32'h0000_000A, 4'h1);
        rd_chk("R5 merge", 4'd4, 32'd10);

        // R6 page size byte lanes
        cfg_wr(4'd8, 32'hAABB_CCDD, 4'h5);
        rd_chk("R6 pgsel", 4'd8, 32'h00BB_00DD);

        // R4 count locked while enabled
        cfg_wr(4'd2, 32'h1, 4'h1);
        cfg_wr(4'd4, 32'd20, 4'h3);
        rd_chk("R4 locked", 4'd4, 32'd10);

        // R9 / R11 lookups, classic layout
        lookup(16'h0300);
        lookup(16'h0303);
        lookup(16'h0301);
        lookup(16'h02FF);
        lookup(16'h031B);
        lookup(16'h031E);

        // R8 forward
        fwd(0);
        fwd(9);
        fwd(10);

        // R10 8-bit-function layout
        cfg_wr(4'd2, 32'h11, 4'h1);
        lookup(16'h031B);
        chk("R10 ari func", 32'(func_a), 32'h1B);

        // disabled
        cfg_wr(4'd2, 32'h0, 4'h1);
        lookup(16'h0300);
        fwd(0);

        // R12 same-cycle write and lookup
        lookup_with_ctrl(16'h0300, 32'h1);
        lookup(16'h0300);
        lookup_with_ctrl(16'h0300, 32'h0);
        lookup(16'h0300);

        // zero count
        cfg_wr(4'd4, 32'd0, 4'h3);
        cfg_wr(4'd2, 32'h1, 4'h1);
        lookup(16'h0300);
        cfg_wr(4'd2, 32'h0, 4'h1);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op;
            op = int'($urandom % 8);
            case (op)
                0: cfg_wr(4'd2, 32'($urandom) & 32'h19, 4'h1);
                1: cfg_wr(4'd4, 32'($urandom % 80), 4'(($urandom % 3) + 1));
                6, 7: fwd(int'($urandom % TOT));
                default: lookup(int'(16'h02F8) + int'($urandom % 210));
            endcase
        end
        rd_chk("R5 final num", 4'd4, 32'(m_num));

        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule